// File: doc/BRIEF.md
# Way-Lockable Four-Way Cache Tag Controller

This block decides, for each cache request, whether the request hits and in which way. On a miss it also decides whether a line is allocated and which way is replaced. It keeps the tag and valid state of a four-way set-associative cache in small internal registers, plus one pseudo-LRU tree per set. The data arrays, the bus side and coherency belong to neighbouring blocks, which act on this block's response.

Software can pin content in place by setting a bit in the lock mask for any subset of the four ways. A locked way still answers lookups, but it is never picked for replacement. A separate mode bit confines the cache to instruction traffic. In that mode data requests skip the cache entirely and go to memory, so they can never push out an instruction line. A line is 256 bits wide and moves as one unit, so the low five address bits select a byte inside the line and take no part in the lookup.

Requests use a valid/ready handshake. Every accepted request gets exactly one registered response in the following cycle. Tag and replacement state change at the same edge that accepts the request, so a request issued straight after it sees the new state.

Top module: `waylock_cache_ctrl`

## Requirements
- R1: A request accepted at a clock edge produces `rspValid`=1 for exactly the next cycle. `rspHit`=1 when a valid line in the indexed set holds the request tag, and `rspHitWay` then gives that way as a binary index 0..3. `rspWrite` repeats the request's write flag. With no accepted request, `rspValid`=0.
- R2: The address is split into offset bits [4:0], set index [8:5] and tag [31:9]. A miss that is allowed to allocate reports `rspAlloc`=1 with the replaced way on `rspVictim`. It installs the tag there, so the same address then hits in that way. Hit and allocate are never both set.
- R3: Addresses that differ only in offset bits [4:0] map to the same 256-bit line.
- R4: If an unlocked invalid way exists in the set, the victim is the lowest-index one.
- R5: If every unlocked way is valid, the victim comes from a three-bit pseudo-LRU tree with locked halves and ways skipped. Touching way 0 or 1 points the root to the upper pair and points the lower-pair bit to the partner way. Touching way 2 or 3 does the same in mirror. After reset every tree points to way 0. Both hits and allocations touch the tree.
- R6: Lock mask bit i locks way i. A locked way is never reported as victim, but lookups still hit in it and still touch the tree.
- R7: With all four ways locked, a miss reports `rspAlloc`=0 and `rspUncached`=1.
- R8: With the instruction-only bit set, a data request (`reqInstr`=0) reports miss, no allocate and `rspUncached`=1 even when its line is present. It leaves tag and replacement state unchanged.
- R9: With the instruction-only bit set, instruction misses still allocate as in R4–R6.
- R10: A configuration write (`cfgWrEn`) takes effect from the next request. A request accepted at the same edge uses the old settings, and the write leaves tag state untouched.
- R11: After reset `rspValid`=0, all lines are invalid, no way is locked, the instruction-only bit is clear, and `reqReady`=1 from the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Loads lock mask and mode bit |
| cfgLockMask | input | 4 | Bit i locks way i |
| cfgInstrOnly | input | 1 | 1: only instruction requests use the cache |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 32 | Byte address |
| reqWrite | input | 1 | 1: store, 0: load |
| reqInstr | input | 1 | 1: instruction side, 0: data side |
| rspValid | output | 1 | Response present this cycle |
| rspHit | output | 1 | Request hit |
| rspHitWay | output | 2 | Way that hit |
| rspAlloc | output | 1 | Miss allocates a line |
| rspVictim | output | 2 | Way that is replaced |
| rspUncached | output | 1 | Miss forwarded to memory without allocation |
| rspWrite | output | 1 | Write flag of the answered request |

## Verification
The hardest state to reach is a full set in which some ways are locked while the pseudo-LRU tree points into a locked half. Only that combination exercises the masked tree walk. The bench builds it directly: it fills a set, touches ways in a chosen order, changes the mask in the same cycle as a request, and then issues misses. A long random phase confined to four sets and eight tags then mixes hits, locks and mode changes. A behavioural model predicts every response from that history.

// File: rtl/waylock_pkg.sv
package waylock_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0] wayIdx_t;

  // Strobes from control to the tag store for the request being accepted.
  typedef struct packed {
    logic    lookupEn;
    logic    allocEn;
    wayIdx_t allocWay;
  } dpStrobe_t;
endpackage

// File: rtl/waylock_tagstore.sv
module waylock_tagstore
  import waylock_pkg::*;
#(
  parameter int TAG_W   = 23,
  parameter int INDEX_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TAG_W-1:0]   reqTag,
  input  logic [INDEX_W-1:0] setIdx,
  input  dpStrobe_t          strobe,
  output logic [WAYS-1:0]    hitVec,
  output logic [WAYS-1:0]    validVec
);
  localparam int SETS = 1 << INDEX_W;

  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];

  logic installNow;
  assign installNow = strobe.lookupEn && strobe.allocEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (installNow) begin
      validQ[setIdx][strobe.allocWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (installNow) tagQ[setIdx][strobe.allocWay] <= reqTag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign validVec[w] = validQ[setIdx][w];
    assign hitVec[w]   = validQ[setIdx][w] && (tagQ[setIdx][w] == reqTag);
  end

  // R1: a tag is never present twice in a set
  assert_single_hit_R1 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookupEn |-> $onehot0(hitVec));

  // R2: control only installs a line on a miss
  assert_alloc_on_miss_R2 : assert property (@(posedge clk) disable iff (!rstN)
    installNow |-> (hitVec == '0));
endmodule

// File: rtl/waylock_ctrl.sv
module waylock_ctrl
  import waylock_pkg::*;
#(
  parameter int INDEX_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [WAYS-1:0]    cfgLockMask,
  input  logic               cfgInstrOnly,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [INDEX_W-1:0] setIdx,
  input  logic               reqWrite,
  input  logic               reqInstr,
  input  logic [WAYS-1:0]    hitVec,
  input  logic [WAYS-1:0]    validVec,
  output dpStrobe_t          strobe,
  output logic               rspValid,
  output logic               rspHit,
  output wayIdx_t            rspHitWay,
  output logic               rspAlloc,
  output wayIdx_t            rspVictim,
  output logic               rspUncached,
  output logic               rspWrite
);
  localparam int SETS = 1 << INDEX_W;

  logic            readyQ;
  logic [WAYS-1:0] lockQ;
  logic            instrOnlyQ;
  logic [SETS-1:0] rootQ, loQ, hiQ;

  logic    fire, bypass, effHit, canAlloc, doAlloc, touch;
  wayIdx_t hitWay, victim, touchWay;

  assign reqReady = readyQ;
  assign fire     = reqValid && readyQ;
  assign bypass   = instrOnlyQ && !reqInstr;
  assign effHit   = (|hitVec) && !bypass;
  assign canAlloc = (lockQ != '1);
  assign doAlloc  = fire && !effHit && !bypass && canAlloc;
  assign touch    = fire && (effHit || doAlloc);
  assign touchWay = effHit ? hitWay : victim;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) if (hitVec[w]) hitWay = wayIdx_t'(w);
  end

  // Victim: lowest unlocked invalid way, else masked pseudo-LRU walk.
  logic foundFree, leftClosed, rightClosed, goRight;
  always_comb begin
    victim    = '0;
    foundFree = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!lockQ[w] && !validVec[w]) begin
        victim    = wayIdx_t'(w);
        foundFree = 1'b1;
      end
    end
    leftClosed  = lockQ[0] && lockQ[1];
    rightClosed = lockQ[2] && lockQ[3];
    goRight     = leftClosed || (!rightClosed && rootQ[setIdx]);
    if (!foundFree) begin
      if (goRight) begin
        if (lockQ[2])      victim = 2'd3;
        else if (lockQ[3]) victim = 2'd2;
        else               victim = hiQ[setIdx] ? 2'd3 : 2'd2;
      end else begin
        if (lockQ[0])      victim = 2'd1;
        else if (lockQ[1]) victim = 2'd0;
        else               victim = loQ[setIdx] ? 2'd1 : 2'd0;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.lookupEn = fire;
    strobe.allocEn  = doAlloc;
    strobe.allocWay = victim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ     <= 1'b0;
      lockQ      <= '0;
      instrOnlyQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      if (cfgWrEn) begin
        lockQ      <= cfgLockMask;
        instrOnlyQ <= cfgInstrOnly;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootQ <= '0;
      loQ   <= '0;
      hiQ   <= '0;
    end else if (touch) begin
      if (!touchWay[1]) begin
        rootQ[setIdx] <= 1'b1;
        loQ[setIdx]   <= !touchWay[0];
      end else begin
        rootQ[setIdx] <= 1'b0;
        hiQ[setIdx]   <= !touchWay[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspHitWay   <= '0;
      rspAlloc    <= 1'b0;
      rspVictim   <= '0;
      rspUncached <= 1'b0;
      rspWrite    <= 1'b0;
    end else begin
      rspValid    <= fire;
      rspHit      <= fire && effHit;
      rspHitWay   <= (fire && effHit) ? hitWay : '0;
      rspAlloc    <= doAlloc;
      rspVictim   <= doAlloc ? victim : '0;
      rspUncached <= fire && !effHit && !doAlloc;
      rspWrite    <= fire && reqWrite;
    end
  end

  // R6: a way locked when the request was taken is never the victim
  assert_locked_not_victim_R6 : assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspAlloc |-> (($past(lockQ) >> rspVictim) & 4'b0001) == 4'b0000);

  // R7: fully locked set forwards misses uncached
  assert_all_locked_uncached_R7 : assert property (@(posedge clk) disable iff (!rstN)
    fire && (lockQ == 4'hF) |=> !rspAlloc && (rspHit || rspUncached));

  // R8: data requests bypass in instruction-only mode
  assert_data_bypass_R8 : assert property (@(posedge clk) disable iff (!rstN)
    fire && instrOnlyQ && !reqInstr |=> rspUncached && !rspHit && !rspAlloc);

  // R2: hit and allocate exclusive
  assert_hit_alloc_excl_R2 : assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspHit && rspAlloc));

  // R1: each accepted request is answered next cycle
  assert_rsp_next_cycle_R1 : assert property (@(posedge clk) disable iff (!rstN)
    fire |=> rspValid);
endmodule

// File: rtl/waylock_cache_ctrl.sv
module waylock_cache_ctrl
  import waylock_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 256,
  parameter int SETS      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [WAYS-1:0]   cfgLockMask,
  input  logic              cfgInstrOnly,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqInstr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspHitWay,
  output logic              rspAlloc,
  output logic [WAY_W-1:0]  rspVictim,
  output logic              rspUncached,
  output logic              rspWrite
);
  localparam int OFFSET_W = $clog2(LINE_BITS / 8);
  localparam int INDEX_W  = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFFSET_W - INDEX_W;

  logic [INDEX_W-1:0] setIdx;
  logic [TAG_W-1:0]   reqTag;
  logic               unusedOffset;
  logic [WAYS-1:0]    hitVec, validVec;
  dpStrobe_t          strobe;

  assign setIdx       = reqAddr[OFFSET_W +: INDEX_W];
  assign reqTag       = reqAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffset = ^reqAddr[OFFSET_W-1:0];

  waylock_tagstore #(.TAG_W(TAG_W), .INDEX_W(INDEX_W)) u_tagstore (
    .clk(clk), .rstN(rstN), .reqTag(reqTag), .setIdx(setIdx),
    .strobe(strobe), .hitVec(hitVec), .validVec(validVec)
  );

  waylock_ctrl #(.INDEX_W(INDEX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgLockMask(cfgLockMask), .cfgInstrOnly(cfgInstrOnly),
    .reqValid(reqValid), .reqReady(reqReady), .setIdx(setIdx),
    .reqWrite(reqWrite), .reqInstr(reqInstr),
    .hitVec(hitVec), .validVec(validVec), .strobe(strobe),
    .rspValid(rspValid), .rspHit(rspHit), .rspHitWay(rspHitWay),
    .rspAlloc(rspAlloc), .rspVictim(rspVictim), .rspUncached(rspUncached),
    .rspWrite(rspWrite)
  );
endmodule

// File: tb/waylock_cache_ctrl_bench.sv
module waylock_cache_ctrl_bench;
  logic clk = 0;
  logic rstN = 0;
  logic cfgWrEn = 0;
  logic [3:0] cfgLockMask = 0;
  logic cfgInstrOnly = 0;
  logic reqValid = 0;
  logic reqReady;
  logic [31:0] reqAddr = 0;
  logic reqWrite = 0;
  logic reqInstr = 0;
  logic rspValid, rspHit, rspAlloc, rspUncached, rspWrite;
  logic [1:0] rspHitWay, rspVictim;

  always #10 clk = ~clk;

  waylock_cache_ctrl u_waylock_cache_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgLockMask(cfgLockMask),
    .cfgInstrOnly(cfgInstrOnly), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqInstr(reqInstr),
    .rspValid(rspValid), .rspHit(rspHit), .rspHitWay(rspHitWay),
    .rspAlloc(rspAlloc), .rspVictim(rspVictim), .rspUncached(rspUncached),
    .rspWrite(rspWrite)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // Behavioural model state
  bit mValid [16][4];
  int mTag   [16][4];
  bit mUp    [16];   // replacement leans to ways 2/3
  bit mOdd0  [16];   // among 0/1, way 1 is older
  bit mOdd2  [16];   // among 2/3, way 3 is older
  bit [3:0] mLock = 0;
  bit mIonly = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pickVictim(int s);
    bit goUp;
    for (int w = 0; w < 4; w++) if (!mLock[w] && !mValid[s][w]) return w;
    if (mLock == 4'hF) return -1;
    if (mLock[0] && mLock[1]) goUp = 1;
    else if (mLock[2] && mLock[3]) goUp = 0;
    else goUp = mUp[s];
    if (goUp) begin
      if (mLock[2]) return 3;
      if (mLock[3]) return 2;
      return mOdd2[s] ? 3 : 2;
    end
    if (mLock[0]) return 1;
    if (mLock[1]) return 0;
    return mOdd0[s] ? 1 : 0;
  endfunction

  function automatic void touchWay(int s, int w);
    if (w < 2) begin mUp[s] = 1; mOdd0[s] = (w == 0); end
    else begin mUp[s] = 0; mOdd2[s] = (w == 2); end
  endfunction

  // Issue one request (optionally with a configuration write in the same cycle)
  // and compare the full response one cycle later.
  task automatic doReq(int tag, int s, int off, bit wr, bit ins, string req,
                       bit cfg = 0, bit [3:0] lk = 0, bit io = 0);
    int hw, vic, hit, alloc;
    bit [8:0] expV, actV;
    reqAddr  = {tag[22:0], s[3:0], off[4:0]};
    reqWrite = wr;
    reqInstr = ins;
    reqValid = 1;
    cfgWrEn  = cfg;
    cfgLockMask = lk;
    cfgInstrOnly = io;
    hw = 0; hit = 0; vic = 0; alloc = 0;
    if (!(mIonly && !ins)) begin
      for (int w = 0; w < 4; w++)
        if (mValid[s][w] && mTag[s][w] == tag) begin hit = 1; hw = w; end
      if (hit) touchWay(s, hw);
      else begin
        vic = pickVictim(s);
        if (vic >= 0) begin
          alloc = 1;
          mValid[s][vic] = 1;
          mTag[s][vic] = tag;
          touchWay(s, vic);
        end else vic = 0;
      end
    end
    if (cfg) begin mLock = lk; mIonly = io; end
    expV = {1'b1, hit[0], hw[1:0], alloc[0], vic[1:0], !(hit[0] | alloc[0]), wr};
    @(negedge clk);
    reqValid = 0;
    cfgWrEn = 0;
    actV = {rspValid, rspHit, rspHitWay, rspAlloc, rspVictim, rspUncached, rspWrite};
    check(actV == expV, req, "response{v,hit,way,alloc,vic,unc,wr}", actV, expV);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      reqValid = 0;
      @(negedge clk);
      check(rspValid == 0, "R1", "rspValid when idle", rspValid, 0);
    end
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      mUp[s] = 0; mOdd0[s] = 0; mOdd2[s] = 0;
      for (int w = 0; w < 4; w++) begin mValid[s][w] = 0; mTag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    check(rspValid == 0, "R11", "rspValid in reset", rspValid, 0);
    rstN = 1;
    @(negedge clk);
    check(reqReady == 1, "R11", "reqReady after reset", reqReady, 1);
    check(rspValid == 0, "R11", "rspValid after reset", rspValid, 0);

    // Fill set 1: invalid ways chosen lowest first
    doReq(1, 1, 0, 0, 1, "R4");
    doReq(2, 1, 0, 1, 0, "R4");
    doReq(3, 1, 0, 0, 1, "R4");
    doReq(4, 1, 0, 0, 0, "R4");
    idle(2);
    // Hits in every way, offset variants
    doReq(1, 1, 31, 0, 1, "R3");
    doReq(2, 1, 4, 0, 0, "R1");
    doReq(3, 1, 0, 1, 1, "R1");
    doReq(4, 1, 17, 0, 0, "R3");
    // Full set: pseudo-LRU victims
    doReq(5, 1, 0, 0, 1, "R5");
    doReq(6, 1, 0, 0, 1, "R5");
    doReq(2, 1, 0, 0, 1, "R5");
    doReq(7, 1, 0, 0, 0, "R5");
    // Lock lower pair in the same cycle as a miss: miss uses old mask (R10)
    doReq(8, 1, 0, 0, 1, "R10", 1, 4'b0011, 0);
    doReq(9, 1, 0, 0, 1, "R6");
    doReq(10, 1, 0, 0, 1, "R6");
    doReq(11, 1, 0, 0, 1, "R6");
    // Hits in locked ways still answer and touch the tree
    for (int t = 1; t < 12; t++) doReq(t, 1, 0, 0, 1, "R6");
    doReq(12, 1, 0, 0, 1, "R6");
    // Lock odd ways only: masked walk inside pairs
    doReq(13, 2, 0, 0, 1, "R10", 1, 4'b1010, 0);
    doReq(13, 1, 0, 0, 1, "R6");
    doReq(14, 1, 0, 0, 1, "R6");
    // All locked
    doReq(1, 3, 0, 0, 1, "R10", 1, 4'b1111, 0);
    doReq(20, 1, 0, 1, 1, "R7");
    doReq(21, 1, 0, 0, 0, "R7");
    doReq(13, 1, 0, 0, 1, "R7");
    // Unlock and enter instruction-only mode
    idle(1);
    doReq(2, 2, 0, 0, 1, "R10", 1, 4'b0000, 1);
    doReq(13, 2, 0, 0, 0, "R8");
    doReq(13, 1, 0, 0, 0, "R8");
    doReq(30, 1, 0, 1, 0, "R8");
    doReq(31, 1, 0, 0, 1, "R9");
    doReq(31, 1, 0, 0, 1, "R9");
    doReq(32, 5, 0, 0, 1, "R9");
    doReq(33, 5, 0, 1, 0, "R8");
    doReq(33, 5, 0, 0, 1, "R9", 1, 4'b0000, 0);
    doReq(32, 5, 0, 0, 0, "R2");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 31);
      if (r == 0) idle(1);
      else if (r == 1)
        doReq($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 31),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R10",
              1, 4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0));
      else
        doReq($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 31),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2");
    end
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule